// File: doc/BRIEF.md
# Four-Bank DRAM Command Scheduler

This block turns single read, write and precharge-all requests into command strobes for a double data rate SDRAM with four independent banks. Each read or write request names a bank, a row and a column. The block keeps a record for each bank of whether a row is open and which row it is. A request to an idle bank produces an activate followed by the column command. A request to the open row produces the column command only. A request to a different row first precharges the bank, then activates the new row, then issues the column command.

Every minimum command gap is a cycle-count parameter. Per-bank down-counters cover activate-to-column, activate-to-precharge, activate-to-activate on one bank, precharge-to-activate and write or read recovery before precharge. Shared counters cover activate-to-activate across banks and write-to-read turnaround. Requests use a valid/ready handshake. Ready falls while the accepted request is waiting on a timing counter. Ready rises again in the cycle that its final command is decided, so row hits can stream one column command per clock.

Top module: `dram_cmd_sched`

## Requirements
- R1: While reset is asserted, `cs_n`, `ras_n`, `cas_n` and `we_n` are all high and `req_ready` is low. No later than four clocks after reset is released, `req_ready` is high.
- R2: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} is 011 for activate, 101 for read, 100 for write and 010 for precharge. `cs_n` stays high in any cycle with no command. `req_op` is 0 for read, 1 for write and 2 for precharge-all.
- R3: Activate puts the row on `addr[11:0]` and the bank on `ba`. Read and write put the column on `addr[8:0]` and `req_autopre` on `addr[10]`, with `addr[9]` and `addr[11]` low.
- R4: A read or write to the row already open in its bank issues no activate and no precharge.
- R5: A read or write to a row other than the open one first issues a precharge to that bank with `addr[10]` low, then an activate of the new row.
- R6: Activate to read/write on the same bank is at least T_RCD cycles. Activate to activate is at least T_RRD cycles across banks and at least T_RC cycles on one bank. These gaps are reached exactly when nothing else blocks.
- R7: Activate to precharge on a bank is at least T_RAS cycles. Precharge to the next activate of that bank is at least T_RP cycles, and exactly T_RP cycles when nothing else blocks.
- R8: A precharge comes at least BURST_LEN/2+1+T_WR cycles after a write to that bank, and at least BURST_LEN/2 cycles after a read to it. A read comes at least BURST_LEN/2+1+T_WTR cycles after any write. When nothing else blocks, these gaps are exact.
- R9: A read or write with `addr[10]` high closes its bank with no explicit precharge. The next activate of that bank comes no earlier than T_RP after the later of (activate + T_RAS) and (column command + recovery). With default timing, that activate lands exactly 9 cycles after the previous one.
- R10: A precharge-all request issues one precharge with `addr[10]` high, once every open bank meets its precharge gaps. Afterwards every bank is idle, and an activate follows it exactly T_RP cycles later.
- R11: Back-to-back read requests that hit the open row produce read commands on consecutive clocks.
- R12: After a request is accepted, `req_ready` stays low until the cycle in which its final command is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on a rising edge while valid and ready are both high |
| req_op | input | 2 | 0 read, 1 write, 2 precharge-all |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 9 | Target column |
| req_autopre | input | 1 | Close the bank after the column command |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Row, or column plus auto/all-precharge bit 10 |
| ba | output | 2 | Bank address |

## Verification
The command for a request is decided in the cycle after the accepting edge, and it reaches the pins one edge later. The bench therefore timestamps each command on the falling edge after it appears, and all gaps are measured between those timestamps. A monitor holds its own model of each bank's open row and earliest legal times, and it checks every command against that model for kind, fields and minimum gap. Directed sequences then compare recorded timestamps with the exact gaps that are due when only one limit applies. Ready is sampled on the falling edge, because it depends only on registered state.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_PREALL = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ACT,
    CMD_READ,
    CMD_WRITE,
    CMD_PRE,
    CMD_PREALL
  } cmd_e;
endpackage

// File: rtl/dcs_bank_track.sv
module dcs_bank_track #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 4,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9,
  parameter int T_RP  = 3,
  parameter int R2P   = 2,
  parameter int W2P   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic             closing_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             col_ok_o,
  output logic             pre_ok_o
);
  logic             open_q, open_d;
  logic             closing_q, closing_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [CNT_W-1:0] rcd_q, rcd_d, ras_q, ras_d, rc_q, rc_d, rp_q, rp_d, rec_q, rec_d;
  logic [CNT_W-1:0] rec_dec, rec_load;
  logic             fire;

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  // auto-precharge takes effect once row-active time and recovery have both elapsed
  assign fire     = closing_q && (ras_q == '0) && (rec_q == '0);
  assign rec_dec  = dec(rec_q);
  assign rec_load = rd_i ? CNT_W'(R2P - 1) : CNT_W'(W2P - 1);

  always_comb begin
    open_d    = open_q;
    closing_d = closing_q;
    row_d     = row_q;
    rcd_d     = dec(rcd_q);
    ras_d     = dec(ras_q);
    rc_d      = dec(rc_q);
    rp_d      = dec(rp_q);
    rec_d     = rec_dec;
    if (act_i) begin
      open_d = 1'b1;
      row_d  = row_i;
      rcd_d  = CNT_W'(T_RCD - 1);
      ras_d  = CNT_W'(T_RAS - 1);
      rc_d   = CNT_W'(T_RC - 1);
    end
    if (rd_i || wr_i) begin
      rec_d = (rec_dec > rec_load) ? rec_dec : rec_load;
      if (ap_i) begin
        open_d    = 1'b0;
        closing_d = 1'b1;
      end
    end
    if (pre_i) begin
      open_d = 1'b0;
      rp_d   = CNT_W'(T_RP - 1);
    end
    if (fire) begin
      closing_d = 1'b0;
      rp_d      = CNT_W'(T_RP - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      closing_q <= 1'b0;
      row_q     <= '0;
      rcd_q     <= '0;
      ras_q     <= '0;
      rc_q      <= '0;
      rp_q      <= '0;
      rec_q     <= '0;
    end else begin
      open_q    <= open_d;
      closing_q <= closing_d;
      rcd_q     <= rcd_d;
      ras_q     <= ras_d;
      rc_q      <= rc_d;
      rp_q      <= rp_d;
      rec_q     <= rec_d;
      if (act_i) row_q <= row_d;
    end
  end

  assign open_o    = open_q;
  assign closing_o = closing_q;
  assign row_o     = row_q;
  assign act_ok_o  = !open_q && !closing_q && (rp_q == '0) && (rc_q == '0);
  assign col_ok_o  = rcd_q == '0;
  assign pre_ok_o  = (ras_q == '0) && (rec_q == '0);

  AST_ACT_ON_IDLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && !closing_q && rp_q == '0 && rc_q == '0)); // R6
  AST_COL_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i || wr_i) |-> (open_q && rcd_q == '0)); // R6
  AST_PRE_RECOVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && open_q) |-> (ras_q == '0 && rec_q == '0)); // R8
  AST_CLOSING_NOT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    closing_q |-> !open_q); // R9
endmodule

// File: rtl/dcs_cmd_encode.sv
module dcs_cmd_encode
  import dcs_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o
);
  logic [3:0]        strb_d;
  logic [ROW_W-1:0]  addr_d;
  logic [BANK_W-1:0] ba_d;

  always_comb begin
    strb_d = 4'b1111;
    addr_d = '0;
    ba_d   = bank_i;
    case (cmd_i)
      CMD_ACT: begin
        strb_d = 4'b0011;
        addr_d = row_i;
      end
      CMD_READ, CMD_WRITE: begin
        strb_d         = (cmd_i == CMD_READ) ? 4'b0101 : 4'b0100;
        addr_d         = ROW_W'(col_i);
        addr_d[AP_BIT] = ap_i;
      end
      CMD_PRE: strb_d = 4'b0010;
      CMD_PREALL: begin
        strb_d         = 4'b0010;
        addr_d[AP_BIT] = 1'b1;
        ba_d           = '0;
      end
      default: ba_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b1111;
      addr_o <= '0;
      ba_o   <= '0;
    end else begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= strb_d;
      addr_o <= addr_d;
      ba_o   <= ba_d;
    end
  end

  AST_DESEL_WITHOUT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_NONE) |=> cs_n_o); // R2
  AST_CMD_DRIVES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != CMD_NONE) |=> !cs_n_o); // R2
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
  import dcs_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba
);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int R2P  = BURST_LEN / 2;
  localparam int W2P  = BURST_LEN / 2 + 1 + T_WR;
  localparam int W2R  = BURST_LEN / 2 + 1 + T_WTR;
  localparam int M1   = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int M2   = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int M3   = (W2P > W2R) ? W2P : W2R;
  localparam int M4   = (M1 > M2) ? M1 : M2;
  localparam int M5   = (M3 > T_RRD) ? M3 : T_RRD;
  localparam int CMAX = (M4 > M5) ? M4 : M5;
  localparam int CNT_W = $clog2(CMAX + 1);

  // reset synchronizer: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic              busy_q, busy_d;
  op_e               pend_op_q;
  logic [BANK_W-1:0] pend_bank_q;
  logic [ROW_W-1:0]  pend_row_q;
  logic [COL_W-1:0]  pend_col_q;
  logic              pend_ap_q;
  logic [CNT_W-1:0]  rrd_q, rrd_d, wtr_q, wtr_d;

  logic [NUM_BANKS-1:0] b_open, b_closing, b_act_ok, b_col_ok, b_pre_ok;
  logic [NUM_BANKS-1:0] b_act, b_pre, b_rd, b_wr;
  logic [ROW_W-1:0]     b_row [NUM_BANKS];

  cmd_e cmd;
  logic done, accept, all_quiet, row_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
      assign b_act[gi] = (cmd == CMD_ACT)   && (pend_bank_q == BANK_W'(gi));
      assign b_rd[gi]  = (cmd == CMD_READ)  && (pend_bank_q == BANK_W'(gi));
      assign b_wr[gi]  = (cmd == CMD_WRITE) && (pend_bank_q == BANK_W'(gi));
      assign b_pre[gi] = ((cmd == CMD_PRE) && (pend_bank_q == BANK_W'(gi))) || (cmd == CMD_PREALL);

      dcs_bank_track #(
        .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
        .T_RC(T_RC), .T_RP(T_RP), .R2P(R2P), .W2P(W2P)
      ) i_bank (
        .clk      (clk),
        .rst_n    (rst_i),
        .act_i    (b_act[gi]),
        .pre_i    (b_pre[gi]),
        .rd_i     (b_rd[gi]),
        .wr_i     (b_wr[gi]),
        .ap_i     (pend_ap_q),
        .row_i    (pend_row_q),
        .open_o   (b_open[gi]),
        .closing_o(b_closing[gi]),
        .row_o    (b_row[gi]),
        .act_ok_o (b_act_ok[gi]),
        .col_ok_o (b_col_ok[gi]),
        .pre_ok_o (b_pre_ok[gi])
      );
    end
  endgenerate

  always_comb begin
    all_quiet = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (b_closing[i] || (b_open[i] && !b_pre_ok[i])) all_quiet = 1'b0;
    end
  end

  assign row_hit = b_open[pend_bank_q] && (b_row[pend_bank_q] == pend_row_q);

  // next-command selection for the request being served
  always_comb begin
    cmd  = CMD_NONE;
    done = 1'b0;
    if (busy_q) begin
      if (pend_op_q == OP_PREALL) begin
        if (all_quiet) begin
          cmd  = CMD_PREALL;
          done = 1'b1;
        end
      end else if (row_hit) begin
        if (b_col_ok[pend_bank_q] && (pend_op_q == OP_WRITE || wtr_q == '0)) begin
          cmd  = (pend_op_q == OP_WRITE) ? CMD_WRITE : CMD_READ;
          done = 1'b1;
        end
      end else if (b_open[pend_bank_q]) begin
        if (b_pre_ok[pend_bank_q]) cmd = CMD_PRE;
      end else if (b_act_ok[pend_bank_q] && rrd_q == '0) begin
        cmd = CMD_ACT;
      end
    end
  end

  assign req_ready = rst_i && (!busy_q || done);
  assign accept    = req_valid && req_ready;

  always_comb begin
    busy_d = busy_q;
    if (accept)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
    rrd_d = (rrd_q == '0) ? '0 : rrd_q - 1'b1;
    wtr_d = (wtr_q == '0) ? '0 : wtr_q - 1'b1;
    if (cmd == CMD_ACT)   rrd_d = CNT_W'(T_RRD - 1);
    if (cmd == CMD_WRITE) wtr_d = CNT_W'(W2R - 1);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy_q      <= 1'b0;
      pend_op_q   <= OP_READ;
      pend_bank_q <= '0;
      pend_row_q  <= '0;
      pend_col_q  <= '0;
      pend_ap_q   <= 1'b0;
      rrd_q       <= '0;
      wtr_q       <= '0;
    end else begin
      busy_q <= busy_d;
      rrd_q  <= rrd_d;
      wtr_q  <= wtr_d;
      if (accept) begin
        pend_op_q   <= op_e'(req_op);
        pend_bank_q <= req_bank;
        pend_row_q  <= req_row;
        pend_col_q  <= req_col;
        pend_ap_q   <= req_autopre;
      end
    end
  end

  dcs_cmd_encode #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
  ) i_enc (
    .clk    (clk),
    .rst_n  (rst_i),
    .cmd_i  (cmd),
    .bank_i (pend_bank_q),
    .row_i  (pend_row_q),
    .col_i  (pend_col_q),
    .ap_i   (pend_ap_q),
    .cs_n_o (cs_n),
    .ras_n_o(ras_n),
    .cas_n_o(cas_n),
    .we_n_o (we_n),
    .addr_o (addr),
    .ba_o   (ba)
  );

  AST_READ_AFTER_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd == CMD_READ) |-> (wtr_q == '0)); // R8
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd == CMD_ACT) |-> (rrd_q == '0)); // R6
  AST_NO_CMD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    !busy_q |-> (cmd == CMD_NONE)); // R12
  AST_ACCEPT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && req_ready) |=> busy_q); // R12
  AST_PREALL_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd == CMD_PREALL) |-> ($countones(b_closing) == 0)); // R10
endmodule

// File: tb/test_dram_cmd_sched.sv
module test_dram_cmd_sched;
  localparam int BL = 4, T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9, T_RRD = 2, T_WR = 2, T_WTR = 1;
  localparam int R2P = BL / 2, W2P = BL / 2 + 1 + T_WR, W2R = BL / 2 + 1 + T_WTR;
  localparam int QN = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_autopre;
  logic [1:0] req_op, req_bank, ba;
  logic [11:0] req_row, addr;
  logic [8:0] req_col;
  logic cs_n, ras_n, cas_n, we_n;

  always #5 clk = ~clk;

  dram_cmd_sched #(
    .BURST_LEN(BL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
    .T_RRD(T_RRD), .T_WR(T_WR), .T_WTR(T_WTR)
  ) i_dram_cmd_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit mon_en = 0;
  int qh = 0, qt = 0;
  logic [1:0]  q_op [QN];
  logic [1:0]  q_bank [QN];
  logic [11:0] q_row [QN];
  logic [8:0]  q_col [QN];
  logic        q_ap [QN];

  bit          mopen [4];
  bit          mauto [4];
  logic [11:0] mrow [4];
  int mact [4], mpre [4], mrec [4];
  int mlast_act = -1000, mlast_wr = -1000;
  int t_act = 0, t_pre = 0, t_rd = 0, t_wr = 0, n_act = 0, n_pre = 0, n_rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: decode each command and check it against the bank model
  always @(negedge clk) begin : mon
    int t, b, h;
    logic [2:0] code, ecode;
    bit is_rd;
    string tag;
    if (mon_en && !cs_n) begin
      t = cyc;
      code = {ras_n, cas_n, we_n};
      if (qh == qt) begin
        chk(1'b0, "R2 unexpected command", int'(code), 0);
      end else begin
        h = qh % QN;
        b = int'(q_bank[h]);
        if (q_op[h] == 2'd2) begin
          chk(code == 3'b010 && addr[10], "R10 precharge-all strobes/A10", int'({code, addr[10]}), 4'b0101);
          for (int i = 0; i < 4; i++) begin
            if (mopen[i]) begin
              chk(t >= mact[i] + T_RAS, "R10 tRAS before precharge-all", t, mact[i] + T_RAS);
              chk(t >= mrec[i], "R10 recovery before precharge-all", t, mrec[i]);
            end
            mopen[i] = 0;
            mauto[i] = 0;
            mpre[i] = imax(mpre[i], t);
          end
          n_pre++;
          t_pre = t;
          qh++;
        end else if (mopen[b] && mrow[b] == q_row[h]) begin
          is_rd = (q_op[h] == 2'd0);
          ecode = is_rd ? 3'b101 : 3'b100;
          chk(code == ecode, "R4 column command on row hit", int'(code), int'(ecode));
          if (code == ecode) begin
            chk(addr == ({3'b000, q_col[h]} | {1'b0, q_ap[h], 10'b0}), "R3 column address", int'(addr),
                int'({3'b000, q_col[h]} | {1'b0, q_ap[h], 10'b0}));
            chk(int'(ba) == b, "R3 column bank", int'(ba), b);
            chk(t >= mact[b] + T_RCD, "R6 tRCD", t, mact[b] + T_RCD);
            if (is_rd) begin
              chk(t >= mlast_wr + W2R, "R8 write-to-read", t, mlast_wr + W2R);
              n_rd++;
              t_rd = t;
            end else begin
              mlast_wr = t;
              t_wr = t;
            end
            mrec[b] = imax(mrec[b], t + (is_rd ? R2P : W2P));
            if (q_ap[h]) begin
              mopen[b] = 0;
              mauto[b] = 1;
              mpre[b] = imax(mact[b] + T_RAS, mrec[b]);
            end
            qh++;
          end
        end else if (mopen[b]) begin
          chk(code == 3'b010 && !addr[10] && int'(ba) == b, "R5 single-bank precharge on row miss",
              int'({code, addr[10]}), 4'b0100);
          if (code == 3'b010) begin
            chk(t >= mact[b] + T_RAS, "R7 tRAS", t, mact[b] + T_RAS);
            chk(t >= mrec[b], "R8 recovery before precharge", t, mrec[b]);
            mopen[b] = 0;
            mauto[b] = 0;
            mpre[b] = t;
            n_pre++;
            t_pre = t;
          end
        end else begin
          chk(code == 3'b011, "R3 activate on idle bank", int'(code), 3);
          if (code == 3'b011) begin
            chk(addr == q_row[h] && int'(ba) == b, "R3 activate row/bank", int'(addr), int'(q_row[h]));
            chk(t >= mact[b] + T_RC, "R6 tRC", t, mact[b] + T_RC);
            chk(t >= mlast_act + T_RRD, "R6 tRRD", t, mlast_act + T_RRD);
            tag = mauto[b] ? "R9 auto-precharge then tRP" : "R7 tRP";
            chk(t >= mpre[b] + T_RP, tag, t, mpre[b] + T_RP);
            mopen[b] = 1;
            mauto[b] = 0;
            mrow[b] = q_row[h];
            mact[b] = t;
            mlast_act = t;
            n_act++;
            t_act = t;
          end
        end
      end
    end
  end

  // called at a falling edge; returns one falling edge after acceptance
  task automatic send(input logic [1:0] op, input logic [1:0] bk, input logic [11:0] row,
                      input logic [8:0] col, input logic ap);
    req_valid = 1'b1;
    req_op = op;
    req_bank = bk;
    req_row = row;
    req_col = col;
    req_autopre = ap;
    while (!req_ready) @(negedge clk);
    q_op[qt % QN] = op;
    q_bank[qt % QN] = bk;
    q_row[qt % QN] = row;
    q_col[qt % QN] = col;
    q_ap[qt % QN] = ap;
    qt++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(qh == qt && req_ready)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R12 watchdog expired: actual %0d expected %0d", qt - qh, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : stim
    int a0, c0, p0, r0;
    for (int i = 0; i < 4; i++) begin
      mopen[i] = 0; mauto[i] = 0; mrow[i] = '0;
      mact[i] = -1000; mpre[i] = -1000; mrec[i] = -1000;
    end
    void'($urandom(32'd20240917));
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = '0; req_bank = '0; req_row = '0; req_col = '0; req_autopre = 1'b0;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1 strobes high in reset", int'({cs_n, ras_n, cas_n, we_n}), 15);
    chk(req_ready == 1'b0, "R1 ready low in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(cs_n == 1'b1, "R2 deselect with no command", int'(cs_n), 1);
    mon_en = 1;

    // R3/R6/R12: idle bank gets activate then read exactly tRCD later
    send(2'd0, 2'd0, 12'h123, 9'h005, 1'b0);
    chk(req_ready == 1'b0, "R12 ready low while activate pending", int'(req_ready), 0);
    wait_idle();
    chk(t_rd - t_act == T_RCD, "R6 activate-to-read gap", t_rd - t_act, T_RCD);

    // R4/R11: four row hits stream on consecutive clocks
    a0 = n_act; p0 = n_pre; r0 = n_rd;
    send(2'd0, 2'd0, 12'h123, 9'h010, 1'b0);
    c0 = cyc + 1;
    send(2'd0, 2'd0, 12'h123, 9'h011, 1'b0);
    send(2'd0, 2'd0, 12'h123, 9'h012, 1'b0);
    send(2'd0, 2'd0, 12'h123, 9'h1ff, 1'b0);
    wait_idle();
    chk(n_rd - r0 == 4, "R11 read count", n_rd - r0, 4);
    chk(t_rd - c0 == 3, "R11 reads on consecutive clocks", t_rd - c0, 3);
    chk(n_act == a0 && n_pre == p0, "R4 no activate or precharge on hit", n_act - a0 + n_pre - p0, 0);

    // R5/R7: row miss precharges, then activates exactly tRP later
    send(2'd0, 2'd0, 12'h055, 9'h001, 1'b0);
    wait_idle();
    chk(n_pre == p0 + 1, "R5 one precharge on miss", n_pre - p0, 1);
    chk(t_act - t_pre == T_RP, "R7 precharge-to-activate gap", t_act - t_pre, T_RP);
    chk(t_rd - t_act == T_RCD, "R6 activate-to-read after miss", t_rd - t_act, T_RCD);

    // R8: read after write to another bank waits exactly the turnaround
    send(2'd1, 2'd2, 12'h040, 9'h001, 1'b0);
    send(2'd0, 2'd0, 12'h055, 9'h002, 1'b0);
    wait_idle();
    chk(t_rd - t_wr == W2R, "R8 write-to-read gap", t_rd - t_wr, W2R);

    // R8: precharge after write waits exactly the write recovery
    send(2'd1, 2'd1, 12'h200, 9'h003, 1'b0);
    send(2'd0, 2'd1, 12'h300, 9'h004, 1'b0);
    wait_idle();
    chk(t_pre - t_wr == W2P, "R8 write-to-precharge gap", t_pre - t_wr, W2P);

    // R9: auto-precharge closes bank without a precharge command
    send(2'd0, 2'd3, 12'h0aa, 9'h007, 1'b1);
    wait_idle();
    a0 = t_act; p0 = n_pre;
    send(2'd0, 2'd3, 12'h0bb, 9'h008, 1'b0);
    wait_idle();
    chk(n_pre == p0, "R9 no explicit precharge", n_pre - p0, 0);
    chk(t_act - a0 == T_RC, "R9 reopen gap", t_act - a0, T_RC);

    // R10: precharge-all then activate exactly tRP later
    repeat (12) @(negedge clk);
    p0 = n_pre;
    send(2'd2, 2'd0, 12'h000, 9'h000, 1'b0);
    send(2'd0, 2'd2, 12'h010, 9'h009, 1'b0);
    wait_idle();
    chk(n_pre == p0 + 1, "R10 single precharge-all", n_pre - p0, 1);
    chk(t_act - t_pre == T_RP, "R10 activate after precharge-all", t_act - t_pre, T_RP);

    // mixed random traffic, checked by the monitor model
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [1:0] op;
      r = $urandom % 16;
      op = (r == 0) ? 2'd2 : ((r < 8) ? 2'd0 : 2'd1);
      send(op, 2'($urandom % 4), 12'($urandom % 4), 9'($urandom % 512), ($urandom % 4) == 0);
      repeat ($urandom % 3) @(negedge clk);
    end
    wait_idle();
    chk(qh == qt, "R12 all requests completed", qt - qh, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule